// File: doc/BRIEF.md
# Display Clock Output Shaper

This block produces the clock that leaves the chip toward a display panel. It takes the internal pixel clock and, when that pixel clock is derived from the on-chip PLL, can hold each of its edges back by a programmable whole number of fast PLL clock cycles. The purpose is to line the outgoing clock up against the panel data lines at board level. After the delay stage, the whole waveform can optionally be inverted.

The delay uses a shift chain clocked on the rising edge of the PLL clock, with one tap per cycle of delay. The delay code is five bits wide. Only its even values are meaningful, and each step of two in the code adds one PLL cycle of lag. When the pixel clock comes from some other source, the delay is bypassed. The invert control still applies in that case.

Top module: `pclk_out_shaper`

## Requirements
- R1: While the reset input is low, with the PLL source selected and a non-zero delay code, the output equals the invert bit, because the chain is cleared.
- R2: With the PLL source selected and code bits [4:1] equal to N (N from 1 to 15), the output equals the pixel clock as it was N PLL cycles earlier. One cycle is counted per rising edge of the PLL clock.
- R3: Delay code 0x00 selects no delay: the output follows the pixel clock in the same cycle.
- R4: Bit 0 of the delay code is ignored, so an odd code gives the same output as the even code just below it.
- R5: When the source-select flag is 0 (not PLL), the output is the undelayed pixel clock, whatever the delay code.
- R6: When the invert bit is 1, the output is the complement of what it would be with the bit at 0. This holds for both clock sources and for every delay code.
- R7: Code 0x1E gives the largest delay, 15 PLL cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | Fast PLL clock that times the delay chain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_clk | input | 1 | Internal pixel clock to be shaped |
| src_is_pll | input | 1 | 1 when the pixel clock is derived from the PLL |
| dly_code | input | 5 | Delay code; bits [4:1] give the number of PLL cycles of delay |
| inv_en | input | 1 | 1 inverts the output clock |
| disp_clk | output | 1 | Display clock output |

## Verification
The bench drives divided clocks with several half periods and sweeps all 32 delay codes against both source settings and both polarities. A behavioural history model gives the expected output for every cycle. The sweep targets an off-by-one tap, which would shift every edge by a cycle; a design that decodes bit 0 of the code, which would make odd codes run one step long; a delay that leaks into the non-PLL path; and an inversion placed only on the delayed path. The top code 0x1E and the zero code are both covered, so a chain one stage short fails at the top code and a spurious register on the zero tap fails at code 0. A pulse of pixel clock high during reset checks that the chain holds its cleared value.

// File: rtl/pcos_pkg.sv
package pcos_pkg;
  // number of one-PLL-cycle delay stages
  parameter int unsigned CHAIN_DEPTH = 15;
  // width of the delay code; bit 0 is not decoded
  parameter int unsigned CODE_W      = 5;
  localparam int unsigned SEL_W      = CODE_W - 1;
endpackage

// File: rtl/pcos_rst_sync.sv
module pcos_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcos_dly_chain.sv
module pcos_dly_chain
  import pcos_pkg::*;
#(
  parameter int unsigned DEPTH = CHAIN_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);
  logic [DEPTH-1:0] stg_q;
  logic [DEPTH-1:0] stg_d;

  always_comb begin
    stg_d = stg_q;
    if (shift_en) begin
      stg_d[0] = din;
      for (int i = 1; i < int'(DEPTH); i++) stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign stages = stg_q;

  generate
    if (DEPTH > 1) begin : g_chk
      AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stg_q[1] == $past(stg_q[0])); // R2
    end
  endgenerate
endmodule

// File: rtl/pcos_tap_sel.sv
module pcos_tap_sel
  import pcos_pkg::*;
#(
  parameter int unsigned DEPTH = CHAIN_DEPTH,
  parameter int unsigned SW    = SEL_W
) (
  input  logic             raw_in,
  input  logic [DEPTH-1:0] stages,
  input  logic [SW-1:0]    sel,
  input  logic             use_chain,
  output logic             tap_out
);
  localparam int unsigned NTAPS = DEPTH + 1;
  logic [NTAPS-1:0] taps;
  logic             picked;

  assign taps = {stages, raw_in};

  always_comb begin
    picked = taps[DEPTH];
    for (int k = 0; k < int'(NTAPS); k++) begin
      if (int'(sel) == k) picked = taps[k];
    end
    tap_out = use_chain ? picked : raw_in;
  end
endmodule

// File: rtl/pclk_out_shaper.sv
module pclk_out_shaper
  import pcos_pkg::*;
(
  input  logic              pll_clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              src_is_pll,
  input  logic [CODE_W-1:0] dly_code,
  input  logic              inv_en,
  output logic              disp_clk
);
  logic                   rst_s_n;
  logic [CHAIN_DEPTH-1:0] chain;
  logic                   tapped;
  logic [SEL_W-1:0]       step_sel;

  assign step_sel = dly_code[CODE_W-1:1];

  pcos_rst_sync #(.STAGES(2)) u_rst (
    .clk    (pll_clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  pcos_dly_chain #(.DEPTH(CHAIN_DEPTH)) u_chain (
    .clk      (pll_clk),
    .rst_n    (rst_s_n),
    .shift_en (1'b1),
    .din      (pix_clk),
    .stages   (chain)
  );

  pcos_tap_sel #(.DEPTH(CHAIN_DEPTH), .SW(SEL_W)) u_tap (
    .raw_in    (pix_clk),
    .stages    (chain),
    .sel       (step_sel),
    .use_chain (src_is_pll),
    .tap_out   (tapped)
  );

  assign disp_clk = tapped ^ inv_en;

  AST_BYPASS_UNDELAYED: assert property (@(posedge pll_clk) disable iff (!rst_s_n)
    !src_is_pll |-> disp_clk == (pix_clk ^ inv_en)); // R5
  AST_ZERO_CODE_DIRECT: assert property (@(posedge pll_clk) disable iff (!rst_s_n)
    (src_is_pll && step_sel == '0) |-> disp_clk == (pix_clk ^ inv_en)); // R3
  AST_POLARITY_LAST: assert property (@(posedge pll_clk) disable iff (!rst_s_n)
    inv_en |-> disp_clk != tapped); // R6
  AST_TOP_TAP_END: assert property (@(posedge pll_clk) disable iff (!rst_s_n)
    (src_is_pll && step_sel == SEL_W'(CHAIN_DEPTH)) |-> (disp_clk ^ inv_en) == chain[CHAIN_DEPTH-1]); // R7
endmodule

// File: tb/pclk_out_shaper_tb_top.sv
module pclk_out_shaper_tb_top;
  logic       pll_clk;
  logic       rst_n;
  logic       pix_clk;
  logic       src_is_pll;
  logic [4:0] dly_code;
  logic       inv_en;
  logic       disp_clk;

  int n_run  = 0;
  int n_fail = 0;
  bit hist[$];
  int half_per = 2;
  int div_cnt  = 0;

  pclk_out_shaper dut_i (
    .pll_clk    (pll_clk),
    .rst_n      (rst_n),
    .pix_clk    (pix_clk),
    .src_is_pll (src_is_pll),
    .dly_code   (dly_code),
    .inv_en     (inv_en),
    .disp_clk   (disp_clk)
  );

  initial pll_clk = 1'b0;
  always #10 pll_clk = ~pll_clk;

  task automatic check(input string req, input bit act, input bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s code=%0h src=%0b inv=%0b actual=%0b expected=%0b",
               req, dly_code, src_is_pll, inv_en, act, exp);
    end
  endtask

  // one PLL cycle: at falling edge update pixel clock, then compare 1 ns later
  task automatic step(input bit run_div, input string req);
    int n;
    bit e;
    @(negedge pll_clk);
    if (run_div) begin
      div_cnt++;
      if (div_cnt >= half_per) begin
        div_cnt = 0;
        pix_clk = ~pix_clk;
      end
    end
    hist.push_front(pix_clk);
    if (hist.size() > 40) void'(hist.pop_back());
    #1;
    n = src_is_pll ? int'(dly_code >> 1) : 0;
    e = (n < hist.size()) ? hist[n] : 1'b0;
    e = e ^ inv_en;
    check(req, disp_clk, e);
  endtask

  initial begin
    rst_n = 1'b0; pix_clk = 1'b0; src_is_pll = 1'b1; dly_code = 5'h1E; inv_en = 1'b0;
    repeat (3) @(negedge pll_clk);
    // R1: chain held clear in reset even with pixel clock high
    pix_clk = 1'b1;
    repeat (3) @(negedge pll_clk);
    #1 check("R1", disp_clk, 1'b0);
    inv_en = 1'b1;
    #1 check("R1", disp_clk, 1'b1);
    pix_clk = 1'b0; inv_en = 1'b0;
    @(negedge pll_clk);
    rst_n = 1'b1;
    repeat (20) step(1'b0, "R1");
    // full sweep of codes, sources, polarities, divider ratios
    for (int hp = 0; hp < 4; hp++) begin
      half_per = (hp == 0) ? 1 : (hp == 1) ? 2 : (hp == 2) ? 3 : 7;
      for (int s = 1; s >= 0; s--) begin
        for (int iv = 0; iv < 2; iv++) begin
          for (int c = 0; c < 32; c++) begin
            src_is_pll = s[0];
            inv_en     = iv[0];
            dly_code   = c[4:0];
            for (int k = 0; k < 20; k++) begin
              if (s == 0)            step(1'b1, "R5");
              else if (c[4:1] == 0)  step(1'b1, "R3");
              else if (c == 31 || c == 30) step(1'b1, "R7");
              else if (c[0])         step(1'b1, "R4");
              else if (iv == 1)      step(1'b1, "R6");
              else                   step(1'b1, "R2");
            end
          end
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule